// File: doc/BRIEF.md
# FSK Modem Special-Symbol Status and Interrupt Controller

This block is the host-facing control and status logic of a four-level FSK data modem. The host writes a small mode word that holds three fields: a low-power flag, an enable for special-symbol interrupts, and the two-bit special symbol to send next. The block reports a status word that holds a sticky interrupt flag, a sticky ready flag and the last received special-symbol value. The modulator and demodulator are not part of this block. They appear only as strobes: a symbol-period tick, a received special symbol with its value, and a sent special symbol. The block drives enables back to them.

A `tx_mode` input selects the direction. In receive mode, received special symbols raise the flags and load the value field. In transmit mode, sent special symbols raise the flags, and the mode word's symbol field is latched onto `tx_s_sym` at each transmit strobe. While the low-power flag is set, the core and transmit-driver enables are off and all symbol events are ignored. After the flag is cleared, events stay masked for a fixed number of symbol ticks while the analog path settles.

Top module: `fsk_sym_ctrl`

## Requirements
- R1: A synchronous active-high `rst` gives receive-side defaults. The low-power flag is 1, so `core_en` and `txdrv_en` are 0. The interrupt enable is 0 and the symbol field is 0. `status` is 4'b0000, `irq` is 0 and `tx_s_sym` is 0.
- R2: While the low-power flag is 1, `core_en` and `txdrv_en` are 0 and special-symbol strobes change nothing in `status`. While the flag is 0, `core_en` is 1 and `txdrv_en` equals `tx_mode`.
- R3: Starting with the first cycle after the low-power flag goes to 0, events are masked until SETTLE_TICKS (default 20) `sym_tick` pulses have been seen. An event in the same cycle as the last of those ticks is still masked.
- R4: In receive mode (`tx_mode`=0), an unmasked `rx_s_stb` with the interrupt enable at 1 sets `status[3]` (IRQ) and `status[2]` (ready) on the next cycle, and loads `status[1:0]` with `rx_s_val`. `tx_s_stb` has no effect in receive mode.
- R5: In transmit mode, an unmasked `tx_s_stb` with the interrupt enable at 1 sets IRQ and ready on the next cycle and leaves `status[1:0]` unchanged. `rx_s_stb` has no effect in transmit mode.
- R6: With the interrupt enable at 0, special-symbol strobes leave `status` unchanged.
- R7: In transmit mode with the low-power flag at 0, `tx_s_stb` copies the mode word's symbol field onto `tx_s_sym` on the next cycle. In receive mode, `tx_s_sym` holds its value whatever the symbol field is.
- R8: A one-cycle `stat_rd` pulse clears IRQ and ready on the next cycle and keeps `status[1:0]`. If an event happens in the same cycle as the read, the event wins and the flags stay set.
- R9: `irq` always equals `status[3]`.
- R10: A `mode_wr` pulse loads the mode word on the next edge. `mode_wdata[3]` is the low-power flag, `mode_wdata[2]` is the interrupt enable and `mode_wdata[1:0]` is the symbol to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 4 | Mode word: low-power, interrupt enable, symbol[1:0] |
| tx_mode | input | 1 | 1 selects transmit, 0 selects receive |
| sym_tick | input | 1 | One pulse per symbol period |
| rx_s_stb | input | 1 | Special symbol received |
| rx_s_val | input | 2 | Value of the received special symbol |
| tx_s_stb | input | 1 | Special symbol sent |
| stat_rd | input | 1 | Host read of the status word |
| status | output | 4 | {IRQ, ready, value[1:0]} |
| irq | output | 1 | Active-high interrupt |
| tx_s_sym | output | 2 | Special symbol presented to the modulator |
| core_en | output | 1 | Filter and symbol/clock recovery enable |
| txdrv_en | output | 1 | Transmit output driver enable |

## Verification
The assertions check these rules on every cycle: the interrupt pin tracks the IRQ bit, a read with no event clears both flags, the value field and the transmit symbol stay frozen while low power or receive mode forbids them to move, and a flag only rises after a strobe in the active direction once the settle count has reached zero. The bench scenarios show the rest. These are the exact tick on which the settle window ends, a read colliding with an event, the effect of the interrupt enable, and the full sequence of writes, mode changes, strobes and reads, all compared against a cycle model.

// File: rtl/fsk_sym_ctrl.sv
module fsk_sym_ctrl #(
  parameter int SETTLE_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [3:0] mode_wdata,
  input  logic       tx_mode,
  input  logic       sym_tick,
  input  logic       rx_s_stb,
  input  logic [1:0] rx_s_val,
  input  logic       tx_s_stb,
  input  logic       stat_rd,
  output logic [3:0] status,
  output logic       irq,
  output logic [1:0] tx_s_sym,
  output logic       core_en,
  output logic       txdrv_en
);
  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_TICKS);

  logic          psave, ien;
  logic [1:0]    ssym;
  logic [CW-1:0] settle_cnt;
  logic          irq_q, srdy_q;
  logic [1:0]    sval_q;
  logic          blank, rx_ev, tx_ev, ev;

  assign blank = psave || (settle_cnt != '0);
  assign rx_ev = !tx_mode && rx_s_stb && ien && !blank;
  assign tx_ev = tx_mode && tx_s_stb && ien && !blank;
  assign ev    = rx_ev || tx_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      psave <= 1'b1;
      ien   <= 1'b0;
      ssym  <= 2'd0;
    end else if (mode_wr) begin
      psave <= mode_wdata[3];
      ien   <= mode_wdata[2];
      ssym  <= mode_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || psave)
      settle_cnt <= RELOAD;
    else if (sym_tick && settle_cnt != '0)
      settle_cnt <= settle_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      srdy_q <= 1'b0;
      sval_q <= 2'd0;
    end else begin
      if (ev) begin
        irq_q  <= 1'b1;
        srdy_q <= 1'b1;
      end else if (stat_rd) begin
        irq_q  <= 1'b0;
        srdy_q <= 1'b0;
      end
      if (rx_ev)
        sval_q <= rx_s_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      tx_s_sym <= 2'd0;
    else if (tx_mode && tx_s_stb && !psave)
      tx_s_sym <= ssym;
  end

  assign status   = {irq_q, srdy_q, sval_q};
  assign irq      = irq_q;
  assign core_en  = !psave;
  assign txdrv_en = !psave && tx_mode;
endmodule

// File: rtl/fsk_sym_ctrl_chk.sv
module fsk_sym_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_mode,
  input logic          rx_s_stb,
  input logic          tx_s_stb,
  input logic          stat_rd,
  input logic [3:0]    status,
  input logic          irq,
  input logic [1:0]    tx_s_sym,
  input logic          core_en,
  input logic [CW-1:0] settle_cnt
);
  assert_irq_pin_R9: assert property (@(posedge clk) disable iff (rst)
    irq == status[3]);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_s_stb && !tx_s_stb) |=> (status[3:2] == 2'b00));

  assert_psave_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    !core_en |=> $stable(status[1:0]));

  assert_rx_hold_txsym_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |=> $stable(tx_s_sym));

  assert_flag_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> $past((!tx_mode && rx_s_stb) || (tx_mode && tx_s_stb)));

  assert_settle_mask_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3]) |-> ($past(settle_cnt) == '0));
endmodule

bind fsk_sym_ctrl fsk_sym_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tx_mode(tx_mode), .rx_s_stb(rx_s_stb),
  .tx_s_stb(tx_s_stb), .stat_rd(stat_rd), .status(status), .irq(irq),
  .tx_s_sym(tx_s_sym), .core_en(core_en), .settle_cnt(settle_cnt)
);

// File: tb/fsk_sym_ctrl_tb.sv
module fsk_sym_ctrl_tb;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst, mode_wr, tx_mode, sym_tick, rx_s_stb, tx_s_stb, stat_rd;
  logic [3:0] mode_wdata;
  logic [1:0] rx_s_val;
  logic [3:0] status;
  logic irq, core_en, txdrv_en;
  logic [1:0] tx_s_sym;

  int checks = 0, fails = 0;

  // model state
  bit m_ps, m_ien, m_irq, m_rdy;
  bit [1:0] m_sym, m_val, m_txs;
  int m_cnt;

  always #2.5 clk = ~clk;

  fsk_sym_ctrl #(.SETTLE_TICKS(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .tx_mode(tx_mode), .sym_tick(sym_tick), .rx_s_stb(rx_s_stb),
    .rx_s_val(rx_s_val), .tx_s_stb(tx_s_stb), .stat_rd(stat_rd),
    .status(status), .irq(irq), .tx_s_sym(tx_s_sym), .core_en(core_en),
    .txdrv_en(txdrv_en)
  );

  function automatic bit masked(bit ps, int cnt);
    return ps || (cnt != 0);
  endfunction

  function automatic bit is_event(bit txm, bit rxs, bit txs, bit ien, bit ps, int cnt);
    return ien && !masked(ps, cnt) && ((!txm && rxs) || (txm && txs));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ps = 1; m_ien = 0; m_sym = 0; m_irq = 0; m_rdy = 0; m_val = 0; m_txs = 0;
    m_cnt = SETTLE;
  endtask

  task automatic step(bit wr, bit [3:0] wd, bit txm, bit tick, bit rxs,
                      bit [1:0] rxv, bit txs, bit rd);
    bit ev;
    @(negedge clk);
    mode_wr = wr; mode_wdata = wd; tx_mode = txm; sym_tick = tick;
    rx_s_stb = rxs; rx_s_val = rxv; tx_s_stb = txs; stat_rd = rd;
    @(posedge clk);
    ev = is_event(txm, rxs, txs, m_ien, m_ps, m_cnt);
    if (ev) begin m_irq = 1; m_rdy = 1; end
    else if (rd) begin m_irq = 0; m_rdy = 0; end
    if (ev && !txm) m_val = rxv;
    if (txm && txs && !m_ps) m_txs = m_sym;
    if (m_ps) m_cnt = SETTLE;
    else if (tick && m_cnt != 0) m_cnt--;
    if (wr) begin m_ps = wd[3]; m_ien = wd[2]; m_sym = wd[1:0]; end
    #1;
    chk("R4 status", status, {m_irq, m_rdy, m_val});
    chk("R9 irq", irq, m_irq);
    chk("R7 tx_s_sym", tx_s_sym, m_txs);
    chk("R2 core_en", core_en, !m_ps);
    chk("R2 txdrv_en", txdrv_en, !m_ps && txm);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_929b));
    rst = 1; mode_wr = 0; mode_wdata = 0; tx_mode = 0; sym_tick = 0;
    rx_s_stb = 0; rx_s_val = 0; tx_s_stb = 0; stat_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    model_reset();
    #1;
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 core_en", core_en, 0);
    chk("R1 txdrv_en", txdrv_en, 0);
    chk("R1 tx_s_sym", tx_s_sym, 0);

    step(1, 4'b1100, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 2'd3, 0, 0);
    chk("R2 lowpower ignores strobe", status, 0);

    step(1, 4'b0100, 0, 0, 0, 0, 0, 0);
    chk("R10 lowpower cleared", core_en, 1);
    for (int i = 0; i < SETTLE - 1; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 2'd1, 0, 0);
    chk("R3 last settle tick masks", status, 0);
    step(0, 0, 0, 0, 1, 2'd2, 0, 0);
    chk("R4 rx event", status, 4'b1110);
    step(0, 0, 0, 0, 1, 2'd1, 1, 1);
    chk("R8 event beats read", status, 4'b1101);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 read clears flags", status, 4'b0001);
    step(1, 4'b0000, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2'd3, 0, 0);
    chk("R6 enable off", status, 4'b0001);
    step(1, 4'b0111, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 2'd2, 1, 0);
    chk("R5 tx event keeps value", status, 4'b1101);
    chk("R7 tx symbol latched", tx_s_sym, 3);
    chk("R2 tx driver on", txdrv_en, 1);
    step(1, 4'b0110, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 rx mode ignores field", tx_s_sym, 3);
    chk("R4 tx strobe ignored in rx", status, 4'b0001);

    for (int n = 0; n < 3000; n++) begin
      bit wr, txm;
      bit [3:0] wd;
      wr = ($urandom_range(0, 39) == 0);
      wd = {($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) != 0), 2'($urandom)};
      txm = ($urandom_range(0, 49) == 0) ? !tx_mode : tx_mode;
      step(wr, wd, txm, ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0),
           2'($urandom), ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule